// File: doc/BRIEF.md
# Dual Time-Counter Snapshot Unit

This block keeps two time-of-day counters side by side: a network-timing counter and a pulse-steered counter. Both advance on every edge of one shared clock (nominally 125 MHz), and each adds its own programmable step on every cycle. Each step is given in nanoseconds with 16 fractional bits. The fraction builds up in a sub-nanosecond accumulator, and each counter shows its time as a seconds count and a nanoseconds count. Neither counter has a clock-domain crossing, because both live in the same domain.

Software asks for a snapshot with a request strobe. In that one cycle the block latches both counters, so the two captured times have no skew between them. It then raises a valid flag, which stays up until software acknowledges it. The captured pair lets a later step map a timestamp taken on one counter onto the other, by counting cycles. For that mapping to hold, neither step may change while a capture is in flight. A step write that arrives then is discarded and flagged.

Top module: `dual_rtc_snap`

## Requirements
- R1: While reset is held, and right after it, both counters read 0 s / 0 ns, all four capture outputs are 0, and snapValid and incErr are 0. Both steps reset to 8 ns, which is 0x080000 in the 46-bit format: integer nanoseconds in bits [45:16], fraction in bits [15:0].
- R2: On every clock edge each counter adds its step to {nanoseconds, fraction}. Carries out of the 16-bit fraction reach the nanosecond count, so a step of 8.5 ns makes the count advance by 8 and by 9 on alternate cycles.
- R3: When the sum reaches or passes 1,000,000,000 ns, the nanosecond count takes the sum minus 1,000,000,000 and the seconds count rises by one on the same edge. The nanosecond output is never at or above 1,000,000,000. A step's integer part must stay below 1,000,000,000.
- R4: The two counters have separate steps. Writing one leaves the other unchanged.
- R5: A step write accepted on a clock edge leaves that edge's advance on the old step. The new step applies from the following edge onward.
- R6: When snapReq is high in a cycle and snapValid is low, the four capture outputs take the seconds and nanoseconds both counters show in that same cycle. snapValid is high from the next cycle.
- R7: While snapValid is high and no acknowledge arrives, snapValid stays high and the captured values do not change, even if a new request arrives.
- R8: snapAck while snapValid is high clears snapValid from the next cycle. snapAck while snapValid is low has no effect.
- R9: A step write (netIncWe or ppsIncWe) in a cycle where snapReq or snapValid is high is discarded. The counter keeps its previous step, and incErr is high for exactly the next cycle.
- R10: An accepted step write leaves incErr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both counters |
| rstN | input | 1 | Active-low synchronous reset |
| snapReq | input | 1 | Snapshot request strobe |
| snapAck | input | 1 | Acknowledge that clears snapValid |
| netIncWe | input | 1 | Step write strobe, network-timing counter |
| netIncVal | input | NS_W+FRAC_W (46) | Step value, ns with 16 fractional bits |
| ppsIncWe | input | 1 | Step write strobe, pulse-steered counter |
| ppsIncVal | input | NS_W+FRAC_W (46) | Step value, ns with 16 fractional bits |
| netSec | output | SEC_W (32) | Network-timing counter seconds |
| netNs | output | NS_W (30) | Network-timing counter nanoseconds |
| ppsSec | output | SEC_W (32) | Pulse-steered counter seconds |
| ppsNs | output | NS_W (30) | Pulse-steered counter nanoseconds |
| snapValid | output | 1 | Captured pair is held and valid |
| incErr | output | 1 | One-cycle flag for a discarded step write |
| snapNetSec | output | SEC_W (32) | Captured network-timing seconds |
| snapNetNs | output | NS_W (30) | Captured network-timing nanoseconds |
| snapPpsSec | output | SEC_W (32) | Captured pulse-steered seconds |
| snapPpsNs | output | NS_W (30) | Captured pulse-steered nanoseconds |

## Verification
The hardest situation to reach is a seconds rollover that coincides with a capture, a fractional carry and a step change. At 8 ns per cycle the first rollover would take 125 million cycles. The stimulus therefore programs steps of hundreds of millions of nanoseconds, some with large fractions, so that rollovers occur every few cycles. Snapshots are requested right after these runs. Discarded writes are made in the same cycle as the request and during the valid window, and the step actually in use is then read back by measuring how far the counter moves.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  // number of time counters held side by side
  localparam int unsigned CNT_N = 2;
  localparam int unsigned NET_IDX = 0;
  localparam int unsigned PPS_IDX = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [CNT_N-1:0] incLoad;
  } snapStrobe_t;

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned NS_ROLL = 1000000000,
  parameter int unsigned INC_W   = NS_W + FRAC_W,
  parameter logic [INC_W-1:0] INC_RST = INC_W'(8) << FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incLoad,
  input  logic [INC_W-1:0] incIn,
  output logic [SEC_W-1:0] secOut,
  output logic [NS_W-1:0]  nsOut
);

  localparam int unsigned ACC_W = INC_W + 1;
  localparam logic [NS_W:0] ROLL_V = (NS_W + 1)'(NS_ROLL);

  logic [INC_W-1:0]  incReg;
  logic [FRAC_W-1:0] fracReg;
  logic [NS_W-1:0]   nsReg;
  logic [SEC_W-1:0]  secReg;

  logic [ACC_W-1:0]  accSum;
  logic [NS_W:0]     sumNs;
  logic              wrapSec;
  logic [NS_W:0]     nsWrapped;
  logic [NS_W-1:0]   nsNext;

  always_comb begin
    accSum    = {1'b0, nsReg, fracReg} + {1'b0, incReg};
    sumNs     = accSum[ACC_W-1:FRAC_W];
    wrapSec   = (sumNs >= ROLL_V);
    nsWrapped = sumNs - ROLL_V;
    nsNext    = wrapSec ? nsWrapped[NS_W-1:0] : sumNs[NS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      incReg  <= INC_RST;
      fracReg <= '0;
      nsReg   <= '0;
      secReg  <= '0;
    end else begin
      fracReg <= accSum[FRAC_W-1:0];
      nsReg   <= nsNext;
      secReg  <= secReg + SEC_W'(wrapSec);
      if (incLoad) begin
        incReg <= incIn;
      end
    end
  end

  assign secOut = secReg;
  assign nsOut  = nsReg;

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import rtc_snap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        snapReq,
  input  logic        snapAck,
  input  logic        netIncWe,
  input  logic        ppsIncWe,
  output snapStrobe_t strobe,
  output logic        snapValid,
  output logic        incErr
);

  logic validQ;
  logic errQ;
  logic pending;
  logic anyWe;

  always_comb begin
    pending                = snapReq || validQ;
    anyWe                  = netIncWe || ppsIncWe;
    strobe.capture         = snapReq && !validQ;
    strobe.incLoad[NET_IDX] = netIncWe && !pending;
    strobe.incLoad[PPS_IDX] = ppsIncWe && !pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= anyWe && pending;
      if (validQ) begin
        validQ <= !snapAck;
      end else begin
        validQ <= snapReq;
      end
    end
  end

  assign snapValid = validQ;
  assign incErr    = errQ;

endmodule

// File: rtl/snap_datapath.sv
module snap_datapath
  import rtc_snap_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned NS_ROLL = 1000000000,
  parameter int unsigned INC_W   = NS_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  snapStrobe_t      strobe,
  input  logic [INC_W-1:0] netIncVal,
  input  logic [INC_W-1:0] ppsIncVal,
  output logic [SEC_W-1:0] netSec,
  output logic [NS_W-1:0]  netNs,
  output logic [SEC_W-1:0] ppsSec,
  output logic [NS_W-1:0]  ppsNs,
  output logic [SEC_W-1:0] snapNetSec,
  output logic [NS_W-1:0]  snapNetNs,
  output logic [SEC_W-1:0] snapPpsSec,
  output logic [NS_W-1:0]  snapPpsNs
);

  logic [INC_W-1:0] incArr  [CNT_N];
  logic [SEC_W-1:0] secArr  [CNT_N];
  logic [NS_W-1:0]  nsArr   [CNT_N];
  logic [SEC_W-1:0] capSec  [CNT_N];
  logic [NS_W-1:0]  capNs   [CNT_N];

  assign incArr[NET_IDX] = netIncVal;
  assign incArr[PPS_IDX] = ppsIncVal;

  for (genvar gi = 0; gi < CNT_N; gi++) begin : g_cnt
    rtc_counter #(
      .SEC_W  (SEC_W),
      .NS_W   (NS_W),
      .FRAC_W (FRAC_W),
      .NS_ROLL(NS_ROLL),
      .INC_W  (INC_W)
    ) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .incLoad(strobe.incLoad[gi]),
      .incIn  (incArr[gi]),
      .secOut (secArr[gi]),
      .nsOut  (nsArr[gi])
    );

    // all captures share the one strobe: same edge for every counter
    always_ff @(posedge clk) begin
      if (!rstN) begin
        capSec[gi] <= '0;
        capNs[gi]  <= '0;
      end else if (strobe.capture) begin
        capSec[gi] <= secArr[gi];
        capNs[gi]  <= nsArr[gi];
      end
    end
  end

  assign netSec     = secArr[NET_IDX];
  assign netNs      = nsArr[NET_IDX];
  assign ppsSec     = secArr[PPS_IDX];
  assign ppsNs      = nsArr[PPS_IDX];
  assign snapNetSec = capSec[NET_IDX];
  assign snapNetNs  = capNs[NET_IDX];
  assign snapPpsSec = capSec[PPS_IDX];
  assign snapPpsNs  = capNs[PPS_IDX];

endmodule

// File: rtl/dual_rtc_snap.sv
module dual_rtc_snap
  import rtc_snap_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned NS_ROLL = 1000000000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    snapReq,
  input  logic                    snapAck,
  input  logic                    netIncWe,
  input  logic [NS_W+FRAC_W-1:0]  netIncVal,
  input  logic                    ppsIncWe,
  input  logic [NS_W+FRAC_W-1:0]  ppsIncVal,
  output logic [SEC_W-1:0]        netSec,
  output logic [NS_W-1:0]         netNs,
  output logic [SEC_W-1:0]        ppsSec,
  output logic [NS_W-1:0]         ppsNs,
  output logic                    snapValid,
  output logic                    incErr,
  output logic [SEC_W-1:0]        snapNetSec,
  output logic [NS_W-1:0]         snapNetNs,
  output logic [SEC_W-1:0]        snapPpsSec,
  output logic [NS_W-1:0]         snapPpsNs
);

  localparam int unsigned INC_W = NS_W + FRAC_W;

  snapStrobe_t strobe;

  snap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .snapReq  (snapReq),
    .snapAck  (snapAck),
    .netIncWe (netIncWe),
    .ppsIncWe (ppsIncWe),
    .strobe   (strobe),
    .snapValid(snapValid),
    .incErr   (incErr)
  );

  snap_datapath #(
    .SEC_W  (SEC_W),
    .NS_W   (NS_W),
    .FRAC_W (FRAC_W),
    .NS_ROLL(NS_ROLL),
    .INC_W  (INC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .netIncVal (netIncVal),
    .ppsIncVal (ppsIncVal),
    .netSec    (netSec),
    .netNs     (netNs),
    .ppsSec    (ppsSec),
    .ppsNs     (ppsNs),
    .snapNetSec(snapNetSec),
    .snapNetNs (snapNetNs),
    .snapPpsSec(snapPpsSec),
    .snapPpsNs (snapPpsNs)
  );

endmodule

// File: rtl/dual_rtc_snap_chk.sv
module dual_rtc_snap_chk #(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned NS_ROLL = 1000000000
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   snapReq,
  input logic                   snapAck,
  input logic                   netIncWe,
  input logic                   ppsIncWe,
  input logic [SEC_W-1:0]       netSec,
  input logic [NS_W-1:0]        netNs,
  input logic [SEC_W-1:0]       ppsSec,
  input logic [NS_W-1:0]        ppsNs,
  input logic                   snapValid,
  input logic                   incErr,
  input logic [SEC_W-1:0]       snapNetSec,
  input logic [NS_W-1:0]        snapNetNs,
  input logic [SEC_W-1:0]       snapPpsSec,
  input logic [NS_W-1:0]        snapPpsNs
);

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (netNs < NS_W'(NS_ROLL)) && (ppsNs < NS_W'(NS_ROLL)));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((netSec == $past(netSec)) || (netSec == $past(netSec) + SEC_W'(1))));

  // R6
  same_cycle_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snapReq && !snapValid) |=> (snapValid && snapNetNs == $past(netNs) &&
      snapPpsNs == $past(ppsNs) && snapNetSec == $past(netSec) &&
      snapPpsSec == $past(ppsSec)));

  // R6
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snapValid && !snapReq) |=> !snapValid);

  // R7
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snapValid && !snapAck) |=> (snapValid && $stable(snapNetNs) &&
      $stable(snapPpsNs) && $stable(snapNetSec) && $stable(snapPpsSec)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snapValid && snapAck) |=> !snapValid);

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((netIncWe || ppsIncWe) && (snapReq || snapValid)) |=> incErr);

  // R10
  no_false_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(netIncWe || ppsIncWe) |=> !incErr);

endmodule

bind dual_rtc_snap dual_rtc_snap_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .NS_ROLL(NS_ROLL)
) chkInst (.*);

// File: tb/dual_rtc_snap_test.sv
`timescale 1ns/1ps
module dual_rtc_snap_test;

  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int FRAC_W = 16;
  localparam int INC_W  = NS_W + FRAC_W;
  localparam longint ROLL  = 64'd1000000000;
  localparam longint ONE   = 64'd65536;
  localparam int NVEC = 5;

  // vectors: network step, pulse step, cycles to run, then a snapshot
  localparam longint VNET [NVEC] = '{8*ONE, 8*ONE + 32768,
    64'd300000000*ONE, 64'd999999999*ONE + 65535, 64'd123456789*ONE + 4321};
  localparam longint VPPS [NVEC] = '{8*ONE, 7*ONE + 49152,
    64'd333333333*ONE + 21845, 1*ONE + 1, 64'd999999990*ONE};
  localparam int VCYC [NVEC] = '{20, 30, 10, 8, 12};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snapReq = 1'b0, snapAck = 1'b0, netIncWe = 1'b0, ppsIncWe = 1'b0;
  logic [INC_W-1:0] netIncVal = '0, ppsIncVal = '0;
  logic [SEC_W-1:0] netSec, ppsSec, snapNetSec, snapPpsSec;
  logic [NS_W-1:0]  netNs, ppsNs, snapNetNs, snapPpsNs;
  logic snapValid, incErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  longint mNetFx, mPpsFx, mNetSec, mPpsSec, mNetInc, mPpsInc;
  longint mCapNetNs, mCapNetSec, mCapPpsNs, mCapPpsSec;
  bit mValid, mErr;

  always #4 clk = ~clk;

  dual_rtc_snap uut (
    .clk(clk), .rstN(rstN), .snapReq(snapReq), .snapAck(snapAck),
    .netIncWe(netIncWe), .netIncVal(netIncVal),
    .ppsIncWe(ppsIncWe), .ppsIncVal(ppsIncVal),
    .netSec(netSec), .netNs(netNs), .ppsSec(ppsSec), .ppsNs(ppsNs),
    .snapValid(snapValid), .incErr(incErr),
    .snapNetSec(snapNetSec), .snapNetNs(snapNetNs),
    .snapPpsSec(snapPpsSec), .snapPpsNs(snapPpsNs)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic modelReset();
    mNetFx = 0; mPpsFx = 0; mNetSec = 0; mPpsSec = 0;
    mNetInc = 8*ONE; mPpsInc = 8*ONE;
    mCapNetNs = 0; mCapNetSec = 0; mCapPpsNs = 0; mCapPpsSec = 0;
    mValid = 0; mErr = 0;
  endtask

  task automatic compareAll();
    cmp("R2 netNs", longint'(netNs), mNetFx / ONE);
    cmp("R2 ppsNs", longint'(ppsNs), mPpsFx / ONE);
    cmp("R3 netSec", longint'(netSec), mNetSec);
    cmp("R3 ppsSec", longint'(ppsSec), mPpsSec);
    cmp("R7 snapValid", longint'(snapValid), longint'(mValid));
    cmp("R6 snapNetNs", longint'(snapNetNs), mCapNetNs);
    cmp("R6 snapNetSec", longint'(snapNetSec), mCapNetSec);
    cmp("R6 snapPpsNs", longint'(snapPpsNs), mCapPpsNs);
    cmp("R6 snapPpsSec", longint'(snapPpsSec), mCapPpsSec);
    cmp("R9 incErr", longint'(incErr), longint'(mErr));
  endtask

  // one clock: update the reference from the driven inputs, then compare
  task automatic tick();
    longint nf, pf, ns2, ps2, ni, pi;
    bit pend, nv;
    pend = snapReq || mValid;
    nf = mNetFx + mNetInc;
    ns2 = mNetSec;
    if (nf / ONE >= ROLL) begin nf -= ROLL * ONE; ns2++; end
    pf = mPpsFx + mPpsInc;
    ps2 = mPpsSec;
    if (pf / ONE >= ROLL) begin pf -= ROLL * ONE; ps2++; end
    ni = (netIncWe && !pend) ? longint'(netIncVal) : mNetInc;
    pi = (ppsIncWe && !pend) ? longint'(ppsIncVal) : mPpsInc;
    nv = mValid ? !snapAck : snapReq;
    if (!mValid && snapReq) begin
      mCapNetNs = mNetFx / ONE; mCapNetSec = mNetSec;
      mCapPpsNs = mPpsFx / ONE; mCapPpsSec = mPpsSec;
    end
    mErr = (netIncWe || ppsIncWe) && pend;
    mValid = nv;
    mNetFx = nf; mNetSec = ns2; mPpsFx = pf; mPpsSec = ps2;
    mNetInc = ni; mPpsInc = pi;
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic idle();
    snapReq = 0; snapAck = 0; netIncWe = 0; ppsIncWe = 0;
  endtask

  function automatic longint nsDelta(input longint a, input longint b);
    return (b - a + ROLL) % ROLL;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    longint n0, n1, n2, p0, p1, sNs;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while reset is held
    cmp("R1 netNs", longint'(netNs), 0);
    cmp("R1 ppsSec", longint'(ppsSec), 0);
    cmp("R1 snapValid", longint'(snapValid), 0);
    cmp("R1 incErr", longint'(incErr), 0);
    cmp("R1 snapNetNs", longint'(snapNetNs), 0);
    rstN = 1;
    // R1: first advance uses the 8 ns reset step
    tick();
    cmp("R1 first step", longint'(netNs), 8);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      netIncWe = 1; netIncVal = INC_W'(VNET[v]);
      ppsIncWe = 1; ppsIncVal = INC_W'(VPPS[v]);
      tick();
      idle();
      cmp("R10 incErr after accepted write", longint'(incErr), 0);
      for (int c = 0; c < VCYC[v]; c++) tick();
      snapReq = 1;
      tick();
      idle();
      cmp("R6 valid after request", longint'(snapValid), 1);
      tick();
      snapAck = 1;
      tick();
      idle();
      cmp("R8 cleared by ack", longint'(snapValid), 0);
    end

    // R4 + R5: steps are separate and a write takes effect one edge later
    netIncWe = 1; netIncVal = INC_W'(8*ONE);
    ppsIncWe = 1; ppsIncVal = INC_W'(12*ONE);
    tick();
    idle();
    tick();
    n0 = netNs; p0 = ppsNs;
    tick();
    n1 = netNs; p1 = ppsNs;
    cmp("R4 net step", nsDelta(n0, n1), 8);
    cmp("R4 pps step", nsDelta(p0, p1), 12);
    netIncWe = 1; netIncVal = INC_W'(20*ONE);
    tick();
    idle();
    n2 = netNs;
    cmp("R5 old step on write edge", nsDelta(n1, n2), 8);
    cmp("R4 pps untouched by net write", nsDelta(p1, longint'(ppsNs)), 12);
    tick();
    cmp("R5 new step next edge", nsDelta(n2, longint'(netNs)), 20);

    // R9: write in the same cycle as the request
    snapReq = 1; netIncWe = 1; netIncVal = INC_W'(100*ONE);
    sNs = netNs;
    tick();
    idle();
    cmp("R9 incErr on req-cycle write", longint'(incErr), 1);
    cmp("R6 capture is request-cycle value", longint'(snapNetNs), sNs);
    n0 = netNs;
    tick();
    cmp("R9 incErr one cycle only", longint'(incErr), 0);
    cmp("R9 net step unchanged", nsDelta(n0, longint'(netNs)), 20);
    // R9: write while valid is held
    ppsIncWe = 1; ppsIncVal = INC_W'(50*ONE);
    tick();
    idle();
    cmp("R9 incErr during valid", longint'(incErr), 1);
    p0 = ppsNs;
    tick();
    cmp("R9 pps step unchanged", nsDelta(p0, longint'(ppsNs)), 12);
    // R7: a second request while valid changes nothing
    snapReq = 1;
    tick();
    idle();
    cmp("R7 capture held", longint'(snapNetNs), sNs);
    cmp("R7 still valid", longint'(snapValid), 1);
    snapAck = 1;
    tick();
    idle();
    cmp("R8 ack clears", longint'(snapValid), 0);
    // R8: ack with nothing valid has no effect
    snapAck = 1;
    tick();
    idle();
    cmp("R8 stray ack", longint'(snapValid), 0);
    snapReq = 1;
    tick();
    idle();
    cmp("R8 request works after stray ack", longint'(snapValid), 1);
    snapAck = 1;
    tick();
    idle();
    tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule